// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the target side of a two-wire serial bus, placed in front of a byte-addressed memory of up to 65,536 locations. A system clock oversamples the bus. SCL and SDA each pass through a two-flop synchronizer and a stability filter. The engine drives only an open-drain pull-down enable for SDA and never drives SCL.

After a START the engine compares the first byte with its device identity. The identity is a fixed four-bit nibble followed by three strap inputs. On a match the engine acknowledges the byte.

- A write transfer carries a two-byte memory address, high byte first, followed by any number of data bytes.
- Each data byte goes to an external page-write controller as a one-cycle pulse with its address.
- Reads are served from a combinational memory read port, addressed by a single internal address counter.

The same counter serves current-address reads, random reads (address load followed by a repeated START) and sequential reads. It wraps from the top of the array to 0. A START anywhere restarts address matching, and a STOP returns the engine to idle.

Top module: `twm_slave_engine`

## Requirements
- R1: A STOP (SDA rising while SCL is high) returns the engine to idle with SDA released; after a STOP, bytes clocked without a new START are not acknowledged.
- R2: The first byte after START matches only when bits 7..4 equal 1010, bits 3..1 equal strap_i[2:0] (bit 3 = strap_i[2]), and bit 0 selects read (1) or write (0). A mismatch is never acknowledged, and the rest of that transfer leaves the address counter unchanged.
- R3: Every accepted received byte (device byte, both address bytes, write data) is acknowledged by holding SDA low for the whole ninth SCL pulse.
- R4: In a write transfer the two bytes after the device byte load the address counter, high byte first.
- R5: Each write data byte produces exactly one wr_valid_o pulse carrying the counter value and the byte; the counter then advances by one.
- R6: A read that starts directly with a read device byte returns the byte at the counter, which holds the last accessed address plus one; after 0xFFFF this is 0x0000.
- R7: A random read (address load, repeated START, read device byte) returns data starting at the loaded address.
- R8: Each controller ACK after a read byte causes the next sequential byte to be sent, with wrap from 0xFFFF to 0x0000. After a NACK, SDA stays released until the next START or STOP.
- R9: A START seen in the middle of any byte aborts the transfer and restarts device-address matching; an address byte that was only partly received does not load the counter.
- R10: sda_pull_o changes only while SCL is low, except when it is released by a START or STOP.
- R11: Each line is synchronized by two flops, and a level is accepted only after it has been stable for FILT_CYCLES system clocks; shorter pulses on SCL or SDA have no effect.
- R12: From reset until the first START the engine ignores the bus, keeping SDA released and wr_valid_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad (wired-AND bus value) |
| strap_i | input | 3 | Device identity strap bits |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| mem_raddr_o | output | AW | Memory read address (the address counter) |
| mem_rdata_i | input | 8 | Memory read data for mem_raddr_o |
| wr_valid_o | output | 1 | One-cycle pulse: a write data byte is ready |
| wr_addr_o | output | AW | Address of the write data byte |
| wr_data_o | output | 8 | Write data byte |

## Verification
A wrong bit counter or state shows up within one byte time. Either the ninth-clock acknowledge is missing, or it appears one SCL pulse off, which the controller sees as a NACK at the next sample. A corrupted address counter is not visible until the next read or write pulse. At that point the returned data or wr_addr_o differs from the bench's own pointer model, so every transfer in the bench ends with a read or a logged write. A filter that passes short pulses misaligns the device byte at once, and the bench detects this as a lost acknowledge.

// File: rtl/twm_pkg.sv
package twm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_DEV  = 3'd1,
        ST_AHI  = 3'd2,
        ST_ALO  = 3'd3,
        ST_WDAT = 3'd4,
        ST_RDAT = 3'd5
    } twm_state_e;

    localparam int BYTE_W  = 8;
    localparam int ACK_BIT = 8;

endpackage

// File: rtl/twm_line_filter.sv
module twm_line_filter #(
    parameter int   STABLE_CYC = 4,
    parameter logic IDLE_LVL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], line_i};
        if (flt_q.sync[1] == flt_q.lvl) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(STABLE_CYC - 1)) begin
            flt_d.lvl = flt_q.sync[1];
            flt_d.cnt = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '{sync: {2{IDLE_LVL}}, lvl: IDLE_LVL, cnt: '0};
        end else begin
            flt_q <= flt_d;
        end
    end

    assign line_o = flt_q.lvl;

    // R11: the filtered level only moves to a value the synchronizer presented
    assert_filter_agrees_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flt_q.lvl) |-> ($past(flt_q.sync[1]) == flt_q.lvl));

endmodule

// File: rtl/twm_bus_events.sv
module twm_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d.scl = scl_i;
        ev_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '{scl: 1'b1, sda: 1'b1};
        end else begin
            ev_q <= ev_d;
        end
    end

    assign scl_rise_o = scl_i & ~ev_q.scl;
    assign scl_fall_o = ~scl_i & ev_q.scl;
    assign start_o    = scl_i & ev_q.scl & ev_q.sda & ~sda_i;
    assign stop_o     = scl_i & ev_q.scl & ~ev_q.sda & sda_i;

    // R1: a bus condition never coincides with an SCL edge or with the other condition
    assert_cond_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_o, stop_o, scl_rise_o, scl_fall_o}) <= 1);

endmodule

// File: rtl/twm_slave_engine.sv
module twm_slave_engine #(
    parameter int         AW          = 16,
    parameter int         FILT_CYCLES = 4,
    parameter logic [3:0] DEV_ID      = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    strap_i,
    output logic          sda_pull_o,
    output logic [AW-1:0] mem_raddr_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          wr_valid_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o
);
    import twm_pkg::*;

    localparam int HI_W = AW - BYTE_W;
    localparam int NLINE = 2;

    typedef struct packed {
        twm_state_e          state;
        logic [3:0]          bitcnt;
        logic                ack_ph;
        logic                rw;
        logic                mack;
        logic                pull;
        logic [BYTE_W-1:0]   shreg;
        logic [BYTE_W-1:0]   ahi;
        logic [AW-1:0]       ptr;
        logic                wr_v;
        logic [AW-1:0]       wr_addr;
        logic [BYTE_W-1:0]   wr_data;
    } eng_t;

    logic [NLINE-1:0] raw_lines;
    logic [NLINE-1:0] flt_lines;
    logic scl_f, sda_f;
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic do_load;
    eng_t eng_d, eng_q;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_filt
        twm_line_filter #(
            .STABLE_CYC (FILT_CYCLES),
            .IDLE_LVL   (1'b1)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (flt_lines[g])
        );
    end

    assign scl_f = flt_lines[1];
    assign sda_f = flt_lines[0];

    twm_bus_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_f),
        .sda_i      (sda_f),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    always_comb begin
        eng_d      = eng_q;
        eng_d.wr_v = 1'b0;
        do_load    = 1'b0;
        if (stop_ev) begin
            eng_d.state  = ST_IDLE;
            eng_d.pull   = 1'b0;
            eng_d.ack_ph = 1'b0;
        end else if (start_ev) begin
            eng_d.state  = ST_DEV;
            eng_d.bitcnt = '0;
            eng_d.ack_ph = 1'b0;
            eng_d.pull   = 1'b0;
        end else begin
            unique case (eng_q.state)
                ST_IDLE: begin
                end
                ST_RDAT: begin
                    if (!eng_q.ack_ph) begin
                        if (scl_rise && eng_q.bitcnt != 4'(ACK_BIT)) begin
                            eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                        end else if (scl_fall && eng_q.bitcnt == 4'(ACK_BIT)) begin
                            eng_d.pull   = 1'b0;
                            eng_d.ack_ph = 1'b1;
                        end else if (scl_fall) begin
                            eng_d.shreg = {eng_q.shreg[6:0], 1'b0};
                            eng_d.pull  = ~eng_q.shreg[6];
                        end
                    end else begin
                        if (scl_rise) begin
                            eng_d.mack = ~sda_f;
                        end else if (scl_fall) begin
                            if (eng_q.mack) begin
                                do_load = 1'b1;
                            end else begin
                                eng_d.state  = ST_IDLE;
                                eng_d.ack_ph = 1'b0;
                            end
                        end
                    end
                end
                default: begin
                    if (!eng_q.ack_ph) begin
                        if (scl_rise && eng_q.bitcnt != 4'(ACK_BIT)) begin
                            eng_d.shreg  = {eng_q.shreg[6:0], sda_f};
                            eng_d.bitcnt = eng_q.bitcnt + 1'b1;
                        end else if (scl_fall && eng_q.bitcnt == 4'(ACK_BIT)) begin
                            eng_d.pull   = 1'b1;
                            eng_d.ack_ph = 1'b1;
                            case (eng_q.state)
                                ST_DEV: begin
                                    if (eng_q.shreg[7:1] == {DEV_ID, strap_i}) begin
                                        eng_d.rw = eng_q.shreg[0];
                                    end else begin
                                        eng_d.state  = ST_IDLE;
                                        eng_d.pull   = 1'b0;
                                        eng_d.ack_ph = 1'b0;
                                    end
                                end
                                ST_AHI: eng_d.ahi = eng_q.shreg;
                                ST_ALO: eng_d.ptr = {eng_q.ahi[HI_W-1:0], eng_q.shreg};
                                default: begin
                                    eng_d.wr_v    = 1'b1;
                                    eng_d.wr_addr = eng_q.ptr;
                                    eng_d.wr_data = eng_q.shreg;
                                    eng_d.ptr     = eng_q.ptr + 1'b1;
                                end
                            endcase
                        end
                    end else if (scl_fall) begin
                        eng_d.pull   = 1'b0;
                        eng_d.ack_ph = 1'b0;
                        eng_d.bitcnt = '0;
                        case (eng_q.state)
                            ST_DEV:  begin
                                if (eng_q.rw) do_load = 1'b1;
                                else          eng_d.state = ST_AHI;
                            end
                            ST_AHI:  eng_d.state = ST_ALO;
                            default: eng_d.state = ST_WDAT;
                        endcase
                    end
                end
            endcase
        end
        if (do_load) begin
            eng_d.state  = ST_RDAT;
            eng_d.shreg  = mem_rdata_i;
            eng_d.ptr    = eng_q.ptr + 1'b1;
            eng_d.pull   = ~mem_rdata_i[7];
            eng_d.bitcnt = '0;
            eng_d.ack_ph = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_pull_o  = eng_q.pull;
    assign mem_raddr_o = eng_q.ptr;
    assign wr_valid_o  = eng_q.wr_v;
    assign wr_addr_o   = eng_q.wr_addr;
    assign wr_data_o   = eng_q.wr_data;

    // R10: outside START/STOP, the pull-down moves only while filtered SCL is low
    assert_pull_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(eng_q.pull) && !$past(start_ev) && !$past(stop_ev)) |-> !$past(scl_f));

    // R12: idle persists until a START arrives
    assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_IDLE && !start_ev) |=> (eng_q.state == ST_IDLE));

    // R9: START re-arms address matching with SDA released
    assert_start_rearms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (eng_q.state == ST_DEV && !eng_q.pull));

    // R1: STOP leaves the engine idle and released
    assert_stop_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (eng_q.state == ST_IDLE && !sda_pull_o));

    // R5: write pulses last a single cycle
    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R3: no pull-down while idle
    assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_IDLE) |-> !sda_pull_o);

endmodule

// File: tb/twm_slave_engine_bench.sv
module twm_slave_engine_bench;
    localparam int AW = 16;
    localparam int T  = 16;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sda_line;
    logic sda_pull_o, wr_valid_o;
    logic [AW-1:0] mem_raddr_o, wr_addr_o;
    logic [7:0] mem_rdata_i, wr_data_o;

    int checks = 0;
    int errors = 0;
    int wr_n = 0;
    int r10_viol = 0;
    logic [15:0] wr_a [0:7];
    logic [7:0]  wr_d [0:7];
    logic pull_prev = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return 8'(a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    assign sda_line    = sda_drv & ~sda_pull_o;
    assign mem_rdata_i = mem_f(mem_raddr_o);

    twm_slave_engine u_twm_slave_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_drv),
        .sda_i       (sda_line),
        .strap_i     (STRAP),
        .sda_pull_o  (sda_pull_o),
        .mem_raddr_o (mem_raddr_o),
        .mem_rdata_i (mem_rdata_i),
        .wr_valid_o  (wr_valid_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o)
    );

    always @(negedge clk) begin
        if (wr_valid_o) begin
            if (wr_n < 8) begin
                wr_a[wr_n] = wr_addr_o;
                wr_d[wr_n] = wr_data_o;
            end
            wr_n = wr_n + 1;
        end
        if (sda_pull_o !== pull_prev && scl_drv) r10_viol = r10_viol + 1;
        pull_prev = sda_pull_o;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bstart();
        sda_drv = 1'b1; tick(T);
        scl_drv = 1'b1; tick(T);
        sda_drv = 1'b0; tick(T);
        scl_drv = 1'b0; tick(T);
    endtask

    task automatic bstop();
        sda_drv = 1'b0; tick(T);
        scl_drv = 1'b1; tick(T);
        sda_drv = 1'b1; tick(T);
    endtask

    task automatic sbit(input logic b, input bit glitch);
        sda_drv = b;
        if (glitch) begin
            tick(T / 2); scl_drv = 1'b1; tick(2); scl_drv = 1'b0; tick(T / 2 - 2);
        end else begin
            tick(T);
        end
        scl_drv = 1'b1;
        if (glitch && b) begin
            tick(T / 2); sda_drv = 1'b0; tick(2); sda_drv = 1'b1; tick(2 * T - T / 2 - 2);
        end else begin
            tick(2 * T);
        end
        scl_drv = 1'b0; tick(T);
    endtask

    task automatic sbyte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) sbit(b[i], glitch);
        sda_drv = 1'b1; tick(T);
        scl_drv = 1'b1; tick(T);
        acked = (sda_line == 1'b0);
        tick(T);
        scl_drv = 1'b0; tick(T);
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] d);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(T); scl_drv = 1'b1; tick(T);
            d[i] = sda_line;
            tick(T); scl_drv = 1'b0;
        end
        tick(T);
        sda_drv = give_ack ? 1'b0 : 1'b1; tick(T);
        scl_drv = 1'b1; tick(2 * T);
        scl_drv = 1'b0; tick(T);
        sda_drv = 1'b1;
    endtask

    task automatic set_addr(input logic [15:0] a);
        bit ack;
        bstart();
        sbyte({4'hA, STRAP, 1'b0}, 1'b0, ack); chk("R3 device write ack", 32'(ack), 1);
        sbyte(a[15:8], 1'b0, ack);             chk("R3 addr hi ack", 32'(ack), 1);
        sbyte(a[7:0], 1'b0, ack);              chk("R3 addr lo ack", 32'(ack), 1);
    endtask

    task automatic cur_read(input logic [15:0] exp_a, input string req);
        bit ack;
        logic [7:0] d;
        bstart();
        sbyte({4'hA, STRAP, 1'b1}, 1'b0, ack); chk("R3 device read ack", 32'(ack), 1);
        rbyte(1'b0, d); chk(req, 32'(d), 32'(mem_f(exp_a)));
        bstop();
    endtask

    logic [15:0] ptr;
    logic [15:0] ra;
    logic [7:0]  dat [0:3];
    logic [7:0]  rd;
    bit ack;
    int nb;

    initial begin
        repeat (190000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1BAD5EED));
        tick(5);
        rst_n = 1'b1;
        tick(20);
        // R12: reset state
        chk("R12 reset pull", 32'(sda_pull_o), 0);
        chk("R12 reset wr_valid", 32'(wr_valid_o), 0);

        // R12: bus activity without START is ignored
        sbyte({4'hA, STRAP, 1'b1}, 1'b0, ack);
        chk("R12 no ack before START", 32'(ack), 0);
        chk("R12 no write before START", 32'(wr_n), 0);
        sda_drv = 1'b1; tick(T); scl_drv = 1'b1; tick(T);

        // R4 R5: write of three bytes
        wr_n = 0;
        set_addr(16'h1234);
        dat[0] = 8'hA5; dat[1] = 8'h00; dat[2] = 8'hFF;
        for (int k = 0; k < 3; k++) begin
            sbyte(dat[k], 1'b0, ack); chk("R3 write data ack", 32'(ack), 1);
        end
        bstop();
        chk("R5 write count", 32'(wr_n), 3);
        for (int k = 0; k < 3; k++) begin
            chk("R5 write addr", 32'(wr_a[k]), 32'(16'h1234 + 16'(k)));
            chk("R5 write data", 32'(wr_d[k]), 32'(dat[k]));
        end
        ptr = 16'h1237;

        // R6: current address read after the write
        cur_read(ptr, "R6 current read after write");
        ptr = ptr + 1'b1;

        // R1: after STOP, a device byte with no START is not acknowledged
        sbyte({4'hA, STRAP, 1'b1}, 1'b0, ack);
        chk("R1 no ack after STOP", 32'(ack), 0);
        sda_drv = 1'b1; tick(T); scl_drv = 1'b1; tick(T);

        // R7 R8: random read at top of array with wrap
        set_addr(16'hFFFE);
        bstart();
        sbyte({4'hA, STRAP, 1'b1}, 1'b0, ack); chk("R7 read ack", 32'(ack), 1);
        for (int k = 0; k < 3; k++) begin
            rbyte(k < 2, rd);
            chk("R8 sequential wrap data", 32'(rd), 32'(mem_f(16'hFFFE + 16'(k))));
        end
        tick(T);
        chk("R8 released after NACK", 32'(sda_pull_o), 0);
        bstop();
        ptr = 16'h0001;
        cur_read(ptr, "R6 current read after wrap");
        ptr = ptr + 1'b1;

        // R2: identity mismatches
        bstart();
        sbyte({4'hA, STRAP ^ 3'b010, 1'b0}, 1'b0, ack); chk("R2 strap mismatch nack", 32'(ack), 0);
        sbyte(8'h55, 1'b0, ack); chk("R2 ignored after mismatch", 32'(ack), 0);
        sbyte(8'h66, 1'b0, ack);
        bstop();
        bstart();
        sbyte({4'hB, STRAP, 1'b1}, 1'b0, ack); chk("R2 nibble mismatch nack", 32'(ack), 0);
        bstop();
        cur_read(ptr, "R2 counter unchanged");
        ptr = ptr + 1'b1;

        // R9: START in the middle of a partly received low address byte
        bstart();
        sbyte({4'hA, STRAP, 1'b0}, 1'b0, ack);
        sbyte(8'h40, 1'b0, ack);
        for (int i = 0; i < 4; i++) sbit(1'b0, 1'b0);
        cur_read(ptr, "R9 abort during address");
        ptr = ptr + 1'b1;

        // R9: START in the middle of a write data byte
        wr_n = 0;
        set_addr(16'h2000);
        sbyte(8'h11, 1'b0, ack);
        for (int i = 0; i < 3; i++) sbit(1'b1, 1'b0);
        cur_read(16'h2001, "R9 abort during data");
        chk("R9 one write before abort", 32'(wr_n), 1);
        ptr = 16'h2002;

        // R11: short pulses on SCL and SDA are filtered
        bstart();
        sbyte({4'hA, STRAP, 1'b0}, 1'b1, ack); chk("R11 ack despite glitches", 32'(ack), 1);
        sbyte(8'h0A, 1'b1, ack); chk("R11 ack hi despite glitches", 32'(ack), 1);
        sbyte(8'hBC, 1'b0, ack);
        bstop();
        cur_read(16'h0ABC, "R11 address intact");
        ptr = 16'h0ABD;

        // R4 R5 R7: random mix
        for (int it = 0; it < 8; it++) begin
            ra = 16'($urandom);
            nb = 1 + int'($urandom % 4);
            if ($urandom % 2 == 0) begin
                wr_n = 0;
                set_addr(ra);
                for (int k = 0; k < nb; k++) begin
                    dat[k] = 8'($urandom);
                    sbyte(dat[k], 1'b0, ack); chk("R3 random write ack", 32'(ack), 1);
                end
                bstop();
                chk("R5 random write count", 32'(wr_n), 32'(nb));
                for (int k = 0; k < nb; k++) begin
                    chk("R4 random write addr", 32'(wr_a[k]), 32'(ra + 16'(k)));
                    chk("R5 random write data", 32'(wr_d[k]), 32'(dat[k]));
                end
            end else begin
                set_addr(ra);
                bstart();
                sbyte({4'hA, STRAP, 1'b1}, 1'b0, ack); chk("R7 random read ack", 32'(ack), 1);
                for (int k = 0; k < nb; k++) begin
                    rbyte(k < nb - 1, rd);
                    chk("R7 random read data", 32'(rd), 32'(mem_f(ra + 16'(k))));
                end
                bstop();
            end
            ptr = ra + 16'(nb);
        end
        cur_read(ptr, "R6 current read after random mix");

        // R10: pull-down edges only while SCL low
        chk("R10 pull changes with SCL high", 32'(r10_viol), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule